// File: doc/BRIEF.md
# Flash Program/Erase Operation Engine

This block is the execution core behind a flash command decoder. Once the decoder has assembled a complete request, it hands over an operation code, a target address, a data byte and, for buffered programming, up to four bytes with an entry count. The engine then runs the operation against a small on-chip array that is split into blocks, each with its own lock bit. It reports progress and failures through an 8-bit status register.

Real program and erase times are replaced by per-operation cycle-count parameters. Flash rules are enforced:

- Programming can only turn ones into zeros.
- Erase fills a block with ones.
- A locked block refuses writes.
- Failure flags stay set until software clears them.

A test input stands in for the low-programming-voltage detector. A combinational read port exposes the array contents.

Top module: `flash_op_engine`

## Requirements
- R1: An accepted request makes the engine busy starting on the next cycle. It stays busy for exactly the cycle count of that operation: PROG_CYC for single program, BUF_CYC for buffered program, ERASE_CYC for erase, LOCK_CYC for set-lock and CLRLK_CYC for clear-locks. Status bit 7 is 1 when the engine is ready and 0 while it is busy.
- R2: While busy, `status` reads 8'h00 and `status_mask` reads 8'h80. When ready, `status_mask` reads 8'hFF and the reserved bits 6, 2 and 0 read 0.
- R3: Single program (op 3'd1) stores old AND data at the target address. If that result differs from the requested data, status bit 4 is set.
- R4: Buffered program (op 3'd2) writes entries 0 to `req_cnt`, where entry i is taken from `req_buf[8i+7:8i]`. Each entry goes to the target address offset by i, and the offset wraps inside the target block. Each location becomes old AND data, and any mismatch sets bit 4.
- R5: Erase (op 3'd3) sets every location of the addressed block to 8'hFF.
- R6: A program, buffered program or erase that targets a locked block sets bits 1 and 4 and leaves the array unchanged.
- R7: If `vpp_low` is high when a request is accepted, the operation changes nothing and sets bit 3. It also sets bit 5 for erase and clear-locks, and bit 4 for program, buffered program and set-lock.
- R8: Set-lock (op 3'd4) locks the addressed block. Clear-locks (op 3'd5) unlocks every block at once.
- R9: Bits 5, 4, 3 and 1 stay set until `clr_status` is pulsed while the engine is ready. A clear pulse given while busy has no effect.
- R10: Requests that arrive while the engine is busy are ignored, and so are op codes 0, 6 and 7.
- R11: A buffered program request is refused, and the engine stays ready, while bit 4 or bit 5 is set.
- R12: The voltage and lock conditions are sampled only at acceptance. Changes made while the operation runs do not alter its outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the array returns to 8'hFF and all locks clear |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation: 1 program, 2 buffered program, 3 erase, 4 set-lock, 5 clear-locks |
| req_addr | input | ADDR_W | Target address; the top BLK_W bits select the block |
| req_data | input | DATA_W | Data for single program |
| req_buf | input | BUF_DEPTH*DATA_W | Buffered program entries, entry i in slice i |
| req_cnt | input | CNT_W | Index of the last buffered entry (entry count minus one) |
| vpp_low | input | 1 | Test stand-in for low programming voltage |
| clr_status | input | 1 | Clears the error flags when the engine is ready |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array contents at rd_addr |
| status | output | 8 | Status register |
| status_mask | output | 8 | Marks which status bits are valid |

## Verification
On every cycle, the embedded properties check several rules:

- The busy transition after acceptance, with its status/mask pair.
- That the engine holds busy while its counter runs.
- The stickiness of the program and erase failure flags.
- The old-AND-new result of a single program.
- That a locked program leaves the array alone.
- That clear-locks empties the lock set.

Only the bench scenarios can show the rest:

- The exact busy length.
- Buffered wrap inside a block.
- Full-block erase.
- The voltage abort, and its sampling only at acceptance.
- Refusal of buffered programming while an error is pending.
- That a clear pulse during busy is lost.

// File: rtl/flash_op_engine.sv
module flash_op_engine #(
  parameter int ADDR_W    = 6,
  parameter int BLK_W     = 2,
  parameter int DATA_W    = 8,
  parameter int BUF_DEPTH = 4,
  parameter int CNT_W     = $clog2(BUF_DEPTH),
  parameter int PROG_CYC  = 3,
  parameter int BUF_CYC   = 5,
  parameter int ERASE_CYC = 8,
  parameter int LOCK_CYC  = 4,
  parameter int CLRLK_CYC = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [2:0]                  req_op,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_data,
  input  logic [BUF_DEPTH*DATA_W-1:0] req_buf,
  input  logic [CNT_W-1:0]            req_cnt,
  input  logic                        vpp_low,
  input  logic                        clr_status,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  output logic [7:0]                  status,
  output logic [7:0]                  status_mask
);
  localparam int OFF_W = ADDR_W - BLK_W;
  localparam int NBLK  = 1 << BLK_W;
  localparam int BSZ   = 1 << OFF_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TMR_W = 16;
  localparam logic [2:0] OP_PROG = 3'd1, OP_BUF = 3'd2, OP_ERASE = 3'd3,
                         OP_SLOCK = 3'd4, OP_CLOCK = 3'd5;

  logic [DATA_W-1:0]           mem [DEPTH];
  logic [NBLK-1:0]             lock;
  logic                        busy;
  logic [TMR_W-1:0]            tmr;
  logic [2:0]                  op_q;
  logic [ADDR_W-1:0]           addr_q;
  logic [DATA_W-1:0]           data_q;
  logic [BUF_DEPTH*DATA_W-1:0] buf_q;
  logic [CNT_W-1:0]            cnt_q;
  logic                        lk_q, vl_q;
  logic                        e5, e4, e3, e1;
  logic                        miss;

  wire [BLK_W-1:0] req_blk = req_addr[ADDR_W-1 -: BLK_W];
  wire [BLK_W-1:0] blk_q   = addr_q[ADDR_W-1 -: BLK_W];
  wire op_known = (req_op >= OP_PROG) && (req_op <= OP_CLOCK);
  wire accept   = req_valid && !busy && op_known && !(req_op == OP_BUF && (e5 || e4));
  wire done     = busy && (tmr == '0);
  wire wr_op    = (op_q == OP_PROG) || (op_q == OP_BUF) || (op_q == OP_ERASE);

  assign rd_data     = mem[rd_addr];
  assign status      = busy ? 8'h00 : {1'b1, 1'b0, e5, e4, e3, 1'b0, e1, 1'b0};
  assign status_mask = busy ? 8'h80 : 8'hFF;

  function automatic logic [TMR_W-1:0] cyc_of(input logic [2:0] op);
    case (op)
      OP_PROG:  return TMR_W'(PROG_CYC - 1);
      OP_BUF:   return TMR_W'(BUF_CYC - 1);
      OP_ERASE: return TMR_W'(ERASE_CYC - 1);
      OP_SLOCK: return TMR_W'(LOCK_CYC - 1);
      default:  return TMR_W'(CLRLK_CYC - 1);
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] buf_idx(input int i);
    return {blk_q, addr_q[OFF_W-1:0] + OFF_W'(i)};
  endfunction

  always_comb begin
    miss = 1'b0;
    if (op_q == OP_PROG)
      miss = (mem[addr_q] & data_q) != data_q;
    else if (op_q == OP_BUF)
      for (int i = 0; i < BUF_DEPTH; i++)
        if (CNT_W'(i) <= cnt_q)
          miss = miss | ((mem[buf_idx(i)] & buf_q[i*DATA_W +: DATA_W]) != buf_q[i*DATA_W +: DATA_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; tmr <= '0; op_q <= '0; addr_q <= '0; data_q <= '0;
      buf_q <= '0; cnt_q <= '0; lk_q <= 1'b0; vl_q <= 1'b0;
      e5 <= 1'b0; e4 <= 1'b0; e3 <= 1'b0; e1 <= 1'b0; lock <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      if (!busy && clr_status) begin
        e5 <= 1'b0; e4 <= 1'b0; e3 <= 1'b0; e1 <= 1'b0;
      end
      if (accept) begin
        busy   <= 1'b1;
        tmr    <= cyc_of(req_op);
        op_q   <= req_op;
        addr_q <= req_addr;
        data_q <= req_data;
        buf_q  <= req_buf;
        cnt_q  <= req_cnt;
        lk_q   <= lock[req_blk];
        vl_q   <= vpp_low;
      end else if (done) begin
        busy <= 1'b0;
        if (vl_q) begin
          e3 <= 1'b1;
          if (op_q == OP_ERASE || op_q == OP_CLOCK) e5 <= 1'b1;
          else e4 <= 1'b1;
        end else if (lk_q && wr_op) begin
          e1 <= 1'b1;
          e4 <= 1'b1;
        end else begin
          case (op_q)
            OP_PROG: begin
              mem[addr_q] <= mem[addr_q] & data_q;
              if (miss) e4 <= 1'b1;
            end
            OP_BUF: begin
              for (int i = 0; i < BUF_DEPTH; i++)
                if (CNT_W'(i) <= cnt_q)
                  mem[buf_idx(i)] <= mem[buf_idx(i)] & buf_q[i*DATA_W +: DATA_W];
              if (miss) e4 <= 1'b1;
            end
            OP_ERASE:
              for (int i = 0; i < BSZ; i++) mem[{blk_q, OFF_W'(i)}] <= '1;
            OP_SLOCK: lock[blk_q] <= 1'b1;
            default:  lock <= '0;
          endcase
        end
      end else if (busy) begin
        tmr <= tmr - 1'b1;
      end
    end
  end

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (status[7] == 1'b0 && status_mask == 8'h80));

  assert_busy_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmr != '0) |=> busy);

  assert_sticky_e4_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (e4 && !(clr_status && !busy)) |=> e4);

  assert_sticky_e5_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (e5 && !(clr_status && !busy)) |=> e5);

  assert_prog_and_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_PROG && !lk_q && !vl_q) |=> mem[addr_q] == ($past(mem[addr_q]) & data_q));

  assert_locked_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_PROG && lk_q && !vl_q) |=> $stable(mem[addr_q]));

  assert_unlock_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_CLOCK && !vl_q) |=> lock == '0);

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> ($stable(op_q) && $stable(addr_q)));
endmodule

// File: tb/flash_op_engine_tb.sv
module flash_op_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [5:0]  req_addr = '0;
  logic [7:0]  req_data = '0;
  logic [31:0] req_buf = '0;
  logic [1:0]  req_cnt = '0;
  logic        vpp_low = 1'b0;
  logic        clr_status = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [7:0]  rd_data, status, status_mask;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_op_engine u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_buf(req_buf), .req_cnt(req_cnt),
    .vpp_low(vpp_low), .clr_status(clr_status), .rd_addr(rd_addr),
    .rd_data(rd_data), .status(status), .status_mask(status_mask));

  // {clear_first, op, addr, data, vpp_low, expected status, expected read at addr}
  localparam logic [34:0] VEC [0:10] = '{
    {1'b0, 3'd1, 6'h01, 8'hA5, 1'b0, 8'h80, 8'hA5},  // R3 plain program
    {1'b0, 3'd1, 6'h01, 8'h3C, 1'b0, 8'h90, 8'h24},  // R3 AND result, mismatch
    {1'b1, 3'd3, 6'h05, 8'h00, 1'b0, 8'h80, 8'hFF},  // R5 erase block 0
    {1'b0, 3'd4, 6'h12, 8'h00, 1'b0, 8'h80, 8'hFF},  // R8 lock block 1
    {1'b0, 3'd1, 6'h13, 8'h00, 1'b0, 8'h92, 8'hFF},  // R6 program locked
    {1'b1, 3'd3, 6'h1F, 8'h00, 1'b0, 8'h92, 8'hFF},  // R6 erase locked
    {1'b1, 3'd5, 6'h00, 8'h00, 1'b0, 8'h80, 8'hFF},  // R8 unlock all
    {1'b0, 3'd1, 6'h13, 8'h5A, 1'b0, 8'h80, 8'h5A},  // R8 block 1 writable again
    {1'b0, 3'd1, 6'h20, 8'h0F, 1'b1, 8'h98, 8'hFF},  // R7 low voltage program
    {1'b1, 3'd3, 6'h13, 8'h00, 1'b1, 8'hA8, 8'h5A},  // R7 low voltage erase
    {1'b1, 3'd3, 6'h13, 8'h00, 1'b0, 8'h80, 8'hFF}   // R5 erase block 1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk); clr_status = 1'b1;
    @(negedge clk); clr_status = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [5:0] a, input logic [7:0] d, input logic vl);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; vpp_low = vl;
    @(negedge clk);
    req_valid = 1'b0; vpp_low = 1'b0;
  endtask

  task automatic wait_ready();
    while (!status[7]) @(negedge clk);
  endtask

  task automatic peek(input string tag, input logic [5:0] a, input logic [7:0] exp);
    rd_addr = a; #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset status", status, 8'h80);
    check("R2 reset mask", status_mask, 8'hFF);
    peek("R5 reset array", 6'h2A, 8'hFF);

    for (int k = 0; k < 11; k++) begin
      automatic logic [34:0] v = VEC[k];
      if (v[34]) pulse_clear();
      issue(v[33:31], v[30:25], v[24:17], v[16]);
      wait_ready();
      check($sformatf("R3/R5/R6/R7/R8 step %0d status", k), status, v[15:8]);
      peek($sformatf("R3/R5/R6/R7/R8 step %0d data", k), v[30:25], v[7:0]);
    end

    // R1 R2 busy window and length
    issue(3'd1, 6'h02, 8'hF0, 1'b0);
    check("R2 busy status", status, 8'h00);
    check("R2 busy mask", status_mask, 8'h80);
    begin
      int n = 0;
      while (!status[7]) begin n++; @(negedge clk); end
      check("R1 program busy cycles", n, 3);
    end
    check("R2 ready mask", status_mask, 8'hFF);

    // R10 request during busy ignored
    issue(3'd1, 6'h03, 8'h0F, 1'b0);
    req_valid = 1'b1; req_op = 3'd1; req_addr = 6'h04; req_data = 8'h00;
    @(negedge clk); req_valid = 1'b0;
    wait_ready();
    peek("R10 busy request dropped", 6'h04, 8'hFF);
    peek("R10 running op completes", 6'h03, 8'h0F);

    // R10 unknown op
    issue(3'd6, 6'h05, 8'h00, 1'b0);
    check("R10 unknown op stays ready", status[7], 1'b1);

    // R4 buffered program with wrap inside block 2
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd2; req_addr = 6'h2E; req_cnt = 2'd3;
    req_buf = 32'h44332211;
    @(negedge clk); req_valid = 1'b0;
    wait_ready();
    check("R4 buffered status", status, 8'h80);
    peek("R4 entry0", 6'h2E, 8'h11);
    peek("R4 entry1", 6'h2F, 8'h22);
    peek("R4 entry2 wrapped", 6'h20, 8'h33);
    peek("R4 entry3 wrapped", 6'h21, 8'h44);
    peek("R4 beyond count untouched", 6'h22, 8'hFF);

    // R12 voltage change during busy has no effect
    issue(3'd1, 6'h06, 8'h55, 1'b0);
    vpp_low = 1'b1;
    wait_ready();
    vpp_low = 1'b0;
    check("R12 status", status, 8'h80);
    peek("R12 data", 6'h06, 8'h55);

    // R3 mismatch then R9 stickiness
    issue(3'd1, 6'h06, 8'hAA, 1'b0);
    wait_ready();
    check("R3 mismatch status", status, 8'h90);
    peek("R3 mismatch data", 6'h06, 8'h00);
    issue(3'd1, 6'h07, 8'h77, 1'b0);
    wait_ready();
    check("R9 flag survives success", status, 8'h90);

    // R11 buffered program refused while bit 4 set
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd2; req_addr = 6'h30; req_cnt = 2'd0; req_buf = 32'h12;
    @(negedge clk); req_valid = 1'b0;
    check("R11 stays ready", status[7], 1'b1);
    peek("R11 array unchanged", 6'h30, 8'hFF);

    // R9 clear while busy ignored, clear when ready works
    issue(3'd1, 6'h08, 8'h01, 1'b0);
    clr_status = 1'b1; @(negedge clk); clr_status = 1'b0;
    wait_ready();
    check("R9 busy clear ignored", status, 8'h90);
    pulse_clear();
    check("R9 clear when ready", status, 8'h80);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule